// File: doc/BRIEF.md
# Framed SPI engine with frame sync pulse

This block moves one 8-bit word per frame over a serial link, MSB first, with SPI mode 0 clocking (SCK idles low, data is sampled on the rising edge and changes on the falling edge). As master it makes SCK from the system clock and drives the slave-select line. As slave it takes SCK from outside. When framing is enabled, the slave-select line carries a one bit-clock sync pulse of selectable polarity instead of a level select. The pulse can come one bit clock before the first data bit or during it. It is driven by the block, or, for a slave, it can be received from the far end.

Words enter on a valid/ready transmit port. `tx_ready` is high only while the engine is idle and holds no word. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` then stays low until that frame has ended. A source under back-pressure keeps `tx_valid` and `tx_data` steady. The receive side has no back-pressure: `rx_valid` is a one-cycle strobe, and the word on `rx_data` stays put until the next frame ends.

Top module: `fspi_engine`

## Requirements
- R1: After reset the engine is idle: `sck_o` is 0, `rx_valid` is 0, `tx_ready` is 1, and a master with framing off holds `ss_o` at 1.
- R2: A word is taken when `tx_valid` and `tx_ready` are both high. From the next cycle `tx_ready` is 0 until the frame has ended, and then it returns to 1.
- R3: As master, each half period of SCK lasts N system clocks, where N is `cfg_div` and the value 0 counts as 1. SCK idles at 0 and gives exactly 8 rising edges per frame.
- R4: Bits leave on `sdo` MSB first and are captured from `sdi` on the SCK rising edges. `rx_valid` is high for exactly one cycle after the last falling edge, and `rx_data` then holds the 8 captured bits, the first one captured in bit 7.
- R5: As master with `cfg_frame_en`=1, `ss_o` takes the level `cfg_pol` (1 = active high, 0 = active low) for exactly 2N system clocks per frame, for both polarities. At all other times it rests at the inverse of `cfg_pol`.
- R6: With `cfg_coincide`=0 the master's pulse ends before the first SCK rising edge, and no SCK edge appears during the pulse. With `cfg_coincide`=1 the pulse covers the first bit, so exactly one SCK rising edge occurs while it is active.
- R7: With `cfg_frame_en`=0, a master drives `ss_o` to 0 from the start of the frame to its last bit, which is 16N system clocks, and to 1 otherwise. A slave transfers a word after `ss_i` falls to 0.
- R8: A slave with `cfg_frame_en`=1 and `cfg_sync_in`=1 starts when `ss_i` changes to the level `cfg_pol`. Its first data bit is on the first SCK rising edge after that change, and the word passes correctly in both directions.
- R9: A slave with `cfg_frame_en`=1 and `cfg_sync_in`=0 drives the pin (`ss_oe`=1), resting at the inverse of `cfg_pol`. Once a word is loaded it raises the pulse. With `cfg_coincide`=0 the pulse lasts for one external SCK period, and data bits follow on the next 8 periods. With `cfg_coincide`=1 it lasts for the first data bit.
- R10: A master always drives the slave-select pin (`ss_oe`=1), and `cfg_sync_in` has no effect on its pulse or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master (makes SCK), 0 = slave |
| cfg_frame_en | input | 1 | 1 = frame sync pulse on the select line, 0 = plain active-low select |
| cfg_sync_in | input | 1 | Slave only: 0 = drive the pulse, 1 = receive the pulse |
| cfg_pol | input | 1 | Active level of the sync pulse |
| cfg_coincide | input | 1 | 0 = pulse precedes the first bit, 1 = pulse covers the first bit |
| cfg_div | input | DIV_W | SCK half period in system clocks (0 counts as 1) |
| tx_data | input | DATA_W | Word to send |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can take a word |
| rx_data | output | DATA_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe: new word on rx_data |
| sck_o | output | 1 | SCK output (master) |
| sck_i | input | 1 | SCK input (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_o | output | 1 | Select / sync pulse output level |
| ss_oe | output | 1 | Output enable for the select pin |
| ss_i | input | 1 | Select / sync pulse input |

## Verification
The bench uses the default DATA_W=8 and DIV_W=8. It pairs a master with a second instance acting as slave at a half period of 6 clocks. This sweeps every combination of framing, polarity, pulse edge and the master's ignored sync-direction bit, with several words, and the margin covers the slave's synchronizer latency. In a separate self-loopback run the master's prescaler takes the values 0, 1, 2, 3 and 5, which exercises the single-clock half period and the value 0. Finally, the bench clocks the slave-driven pulse mode by hand so that the pulse level and every data bit can be checked against each SCK period.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_BITS = 2'd2
  } fspi_state_e;
endpackage

// File: rtl/fspi_prescaler.sv
module fspi_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/fspi_sync.sv
module fspi_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/fspi_shifter.sv
module fspi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              start,
  input  logic              rise,
  input  logic              shift,
  input  logic              finish,
  input  logic              sdi_bit,
  output logic              sdo,
  output logic              loaded,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] rxreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rxreg    <= '0;
      loaded   <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (start) begin
        loaded <= 1'b0;
        if (accept)       shreg <= tx_word;
        else if (!loaded) shreg <= '0;
      end else if (accept) begin
        shreg  <= tx_word;
        loaded <= 1'b1;
      end else if (shift) begin
        shreg <= {shreg[DATA_W-2:0], 1'b0};
      end
      if (rise) rxreg <= {rxreg[DATA_W-2:0], sdi_bit};
      rx_valid <= finish;
      if (finish) rx_word <= rxreg;
    end
  end

  assign sdo = shreg[DATA_W-1];

  // R4
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/fspi_engine.sv
module fspi_engine
  import fspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_frame_en,
  input  logic              cfg_sync_in,
  input  logic              cfg_pol,
  input  logic              cfg_coincide,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo,
  input  logic              sdi,
  output logic              ss_o,
  output logic              ss_oe,
  input  logic              ss_i
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  fspi_state_e      state;
  logic [CNT_W-1:0] bitcnt;
  logic             sck_q;
  logic             tick;
  logic             run;
  logic [2:0]       pins_s;
  logic             sck_s, ss_s, sdi_s;
  logic             sck_p, ss_p;
  logic             ev_rise, ev_fall;
  logic             ss_act_lvl, ss_edge;
  logic             drive_ss, use_pre, start;
  logic             loaded, accept;
  logic             in_bits, last_bit, shift, finish, rise;
  logic             pulse_on, abort;

  // pin synchronizers for the slave role
  fspi_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdi, ss_i, sck_i}),
    .q     (pins_s)
  );
  assign sck_s = pins_s[0];
  assign ss_s  = pins_s[1];
  assign sdi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b1;
      ss_p  <= 1'b1;
    end else begin
      sck_p <= sck_s;
      ss_p  <= ss_s;
    end
  end

  // bit clock for the master role
  assign run = cfg_master && (state != ST_IDLE);

  fspi_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (cfg_div),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sck_q <= 1'b0;
    else if (state == ST_IDLE)   sck_q <= 1'b0;
    else if (tick)               sck_q <= ~sck_q;
  end

  assign ev_rise = cfg_master ? (tick && !sck_q) : (sck_s && !sck_p);
  assign ev_fall = cfg_master ? (tick && sck_q)  : (!sck_s && sck_p);

  // start conditions
  assign ss_act_lvl = cfg_frame_en ? cfg_pol : 1'b0;
  assign ss_edge    = (ss_s == ss_act_lvl) && (ss_p != ss_act_lvl);
  assign drive_ss   = cfg_master || (cfg_frame_en && !cfg_sync_in);
  assign use_pre    = cfg_frame_en && !cfg_coincide && drive_ss;
  assign start      = (state == ST_IDLE) && (drive_ss ? loaded : ss_edge);
  assign tx_ready   = (state == ST_IDLE) && !loaded;
  assign accept     = tx_valid && tx_ready;

  assign in_bits  = (state == ST_BITS);
  assign last_bit = (bitcnt == LAST);
  assign rise     = in_bits && ev_rise;
  assign shift    = in_bits && ev_fall && !last_bit;
  assign finish   = in_bits && ev_fall && last_bit;
  assign abort    = in_bits && !cfg_master && !cfg_frame_en && ss_s && !finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= use_pre ? ST_PRE : ST_BITS;
            bitcnt <= '0;
          end
        end
        ST_PRE: begin
          if (ev_fall) state <= ST_BITS;
        end
        ST_BITS: begin
          if (finish)     state <= ST_IDLE;
          else if (abort) state <= ST_IDLE;
          else if (shift) bitcnt <= bitcnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fspi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .tx_word  (tx_data),
    .start    (start),
    .rise     (rise),
    .shift    (shift),
    .finish   (finish),
    .sdi_bit  (cfg_master ? sdi : sdi_s),
    .sdo      (sdo),
    .loaded   (loaded),
    .rx_word  (rx_data),
    .rx_valid (rx_valid)
  );

  // select line
  assign pulse_on = (state == ST_PRE) ||
                    (in_bits && (bitcnt == '0) && cfg_coincide && cfg_frame_en);
  assign ss_o  = cfg_frame_en ? (pulse_on ? cfg_pol : ~cfg_pol) : ~in_bits;
  assign ss_oe = drive_ss;
  assign sck_o = cfg_master && sck_q && in_bits;

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R3
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !tick && state != ST_IDLE) |=> $stable(sck_o));

  // R6
  lead_pulse_no_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_frame_en && !cfg_coincide && ss_o == cfg_pol) |-> !sck_o);

  // R7
  plain_sck_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_frame_en && sck_o) |-> !ss_o);
endmodule

// File: tb/fspi_engine_bench.sv
module fspi_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       m_fr = 0, m_pol = 0, m_coin = 0, m_si = 0;
  logic [7:0] m_div = 8'd6;
  logic [7:0] m_txd = 0;
  logic       m_txv = 0;
  logic       m_txr, m_rxv, m_sck, m_sdo, m_ss_o, m_ss_oe;
  logic [7:0] m_rxd;

  logic       s_fr = 0, s_si = 1, s_pol = 0, s_coin = 0;
  logic [7:0] s_txd = 0;
  logic       s_txv = 0;
  logic       s_txr, s_rxv, s_sck_o, s_sdo, s_ss_o, s_ss_oe;
  logic [7:0] s_rxd;

  logic loop = 0, sel_s = 0, bsck_mode = 0, bsck = 0;
  logic ss_wire;
  assign ss_wire = sel_s ? s_ss_o : m_ss_o;

  fspi_engine u_fspi_engine (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b1), .cfg_frame_en(m_fr),
    .cfg_sync_in(m_si), .cfg_pol(m_pol), .cfg_coincide(m_coin), .cfg_div(m_div),
    .tx_data(m_txd), .tx_valid(m_txv), .tx_ready(m_txr),
    .rx_data(m_rxd), .rx_valid(m_rxv), .sck_o(m_sck), .sck_i(1'b0),
    .sdo(m_sdo), .sdi(loop ? m_sdo : s_sdo),
    .ss_o(m_ss_o), .ss_oe(m_ss_oe), .ss_i(1'b1)
  );

  fspi_engine u_fspi_engine_peer (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_frame_en(s_fr),
    .cfg_sync_in(s_si), .cfg_pol(s_pol), .cfg_coincide(s_coin), .cfg_div(8'd4),
    .tx_data(s_txd), .tx_valid(s_txv), .tx_ready(s_txr),
    .rx_data(s_rxd), .rx_valid(s_rxv), .sck_o(s_sck_o),
    .sck_i(bsck_mode ? bsck : m_sck),
    .sdo(s_sdo), .sdi(m_sdo),
    .ss_o(s_ss_o), .ss_oe(s_ss_oe), .ss_i(ss_wire)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // master-side monitor
  logic sck_d = 0;
  int act_cyc, rise_pulse, rise_tot, hi_run, hi_bad, m_cnt, s_cnt, exp_hi;
  logic [7:0] m_got, s_got;
  logic ss_act;
  assign ss_act = m_fr ? (m_ss_o == m_pol) : (m_ss_o == 1'b0);

  always @(posedge clk) begin
    if (m_sck && !sck_d) begin
      rise_tot++;
      if (ss_act) rise_pulse++;
    end
    if (ss_act) act_cyc++;
    if (m_sck) hi_run++;
    else if (sck_d) begin
      if (hi_run != exp_hi) hi_bad++;
      hi_run = 0;
    end
    sck_d = m_sck;
    if (m_rxv) begin m_cnt++; m_got = m_rxd; end
    if (s_rxv) begin s_cnt++; s_got = s_rxd; end
  end

  task automatic clear_mon();
    @(negedge clk);
    act_cyc = 0; rise_pulse = 0; rise_tot = 0; hi_run = 0; hi_bad = 0;
    m_cnt = 0; s_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_m(input logic [7:0] d);
    @(negedge clk);
    m_txd = d; m_txv = 1;
    @(posedge clk);
    while (!m_txr) @(posedge clk);
    @(negedge clk);
    m_txv = 0;
  endtask

  task automatic push_s(input logic [7:0] d);
    @(negedge clk);
    s_txd = d; s_txv = 1;
    @(posedge clk);
    while (!s_txr) @(posedge clk);
    @(negedge clk);
    s_txv = 0;
  endtask

  task automatic run_frame(input logic [7:0] wm, input logic [7:0] ws, input int n);
    int exp_m;
    exp_hi = (n == 0) ? 1 : n;
    clear_mon();
    if (!loop) push_s(ws);
    push_m(wm);
    chk(m_txr == 1'b0, "R2 ready low while busy", m_txr, 0);
    while (m_cnt == 0) @(negedge clk);
    repeat (14) @(negedge clk);
    exp_m = loop ? wm : ws;
    chk(m_got == exp_m[7:0], "R4 master rx word", m_got, exp_m);
    chk(m_cnt == 1, "R4 one rx strobe", m_cnt, 1);
    chk(rise_tot == 8, "R3 eight sck rises", rise_tot, 8);
    chk(hi_bad == 0, "R3 sck high time", hi_bad, 0);
    if (m_fr) begin
      chk(act_cyc == 2 * exp_hi, "R5 pulse width", act_cyc, 2 * exp_hi);
      chk(rise_pulse == int'(m_coin), "R6 rises inside pulse", rise_pulse, int'(m_coin));
      chk(m_ss_o == ~m_pol, "R5 idle level", m_ss_o, int'(~m_pol));
    end else begin
      chk(act_cyc == 16 * exp_hi, "R7 select length", act_cyc, 16 * exp_hi);
      chk(m_ss_o == 1'b1, "R7 idle high", m_ss_o, 1);
    end
    chk(m_ss_oe == 1'b1, "R10 master drives select", m_ss_oe, 1);
    chk(m_txr == 1'b1, "R2 ready back", m_txr, 1);
    if (!loop) begin
      chk(s_got == wm, m_fr ? "R8 slave rx word" : "R7 plain slave rx", s_got, wm);
      chk(s_cnt == 1, m_fr ? "R8 slave strobe" : "R7 plain slave strobe", s_cnt, 1);
    end
  endtask

  initial begin
    // reset state
    do_reset();
    chk(m_sck == 1'b0, "R1 sck idle", m_sck, 0);
    chk(m_rxv == 1'b0, "R1 no rx strobe", m_rxv, 0);
    chk(m_txr == 1'b1, "R1 ready", m_txr, 1);
    chk(m_ss_o == 1'b1, "R1 select idle", m_ss_o, 1);

    // master/slave pair sweep
    for (int cfg = 0; cfg < 16; cfg++) begin
      m_fr = cfg[0]; m_pol = cfg[1]; m_coin = cfg[2]; m_si = cfg[3];
      s_fr = cfg[0]; s_pol = cfg[1]; s_coin = cfg[2]; s_si = 1'b1;
      m_div = 8'd6; loop = 0; sel_s = 0; bsck_mode = 0;
      do_reset();
      for (int w = 0; w < 3; w++) begin
        logic [7:0] wm, ws;
        wm = 8'hA5 ^ 8'(cfg * 37 + w * 91);
        ws = 8'h3C ^ 8'(cfg * 53 + w * 29);
        run_frame(wm, ws, 6);
      end
    end

    // prescaler sweep in self-loopback
    for (int k = 0; k < 5; k++) begin
      int n;
      n = (k == 4) ? 5 : k;
      m_fr = 0; m_pol = 0; m_coin = 0; m_si = 0;
      s_fr = 0; s_si = 1;
      m_div = 8'(n); loop = 1;
      do_reset();
      run_frame(8'h96 ^ 8'(n * 17), 8'h00, n);
      run_frame(8'h01 << n, 8'h00, n);
    end

    // slave drives the sync pulse, bench supplies SCK
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic [7:0] ws;
      int np, bad_d, bad_s;
      logic ss_lvl;
      m_fr = 0; m_div = 8'd6; loop = 0;
      s_fr = 1; s_si = 0; s_pol = cfg[0]; s_coin = cfg[1];
      sel_s = 1; bsck_mode = 1; bsck = 0;
      do_reset();
      chk(s_ss_oe == 1'b1, "R9 slave drives select", s_ss_oe, 1);
      chk(s_ss_o == ~s_pol, "R9 slave idle level", s_ss_o, int'(~s_pol));
      ws = 8'hC3 ^ 8'(cfg * 45);
      push_s(ws);
      repeat (4) @(negedge clk);
      chk(s_ss_o == s_pol, "R9 pulse raised", s_ss_o, int'(s_pol));
      np = s_coin ? 8 : 9;
      bad_d = 0; bad_s = 0;
      for (int p = 0; p < np; p++) begin
        int bi;
        repeat (8) @(negedge clk);
        ss_lvl = (p == 0) ? s_pol : ~s_pol;
        if (s_ss_o != ss_lvl) bad_s++;
        bi = s_coin ? 7 - p : 8 - p;
        if (!(p == 0 && !s_coin) && s_sdo != ws[bi]) bad_d++;
        bsck = 1;
        repeat (8) @(negedge clk);
        bsck = 0;
      end
      repeat (8) @(negedge clk);
      chk(bad_s == 0, "R9 pulse per sck period", bad_s, 0);
      chk(bad_d == 0, "R9 slave data bits", bad_d, 0);
      chk(s_ss_o == ~s_pol, "R9 idle after frame", s_ss_o, int'(~s_pol));
      chk(s_txr == 1'b1, "R9 slave idle again", s_txr, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule